// File: doc/BRIEF.md
# Reference Divider with Dual Postscalers

The block turns a free-running reference clock into two streams of comparison-rate enable pulses. A down-counter divides the reference by a programmable ratio. Every time the counter expires, it advances a cascade of divide-by-two stages. A main channel and an auxiliary channel each pick a tap from that shared cascade with their own select code. Each channel therefore runs at the reference rate divided by the ratio and then by 1, 2, 4 or 8. The channels can run at different rates at the same time, and their pulses always line up where the two rates meet.

Configuration arrives as a one-cycle write strobe that carries a ratio and both select codes. A write is first held in a pending store. Ratios below the legal floor are clamped there, and a sticky error flag is set. The pending values move into the active set only when the whole cascade completes a cycle, which is after eight divider periods. Because of this, no channel ever sees a shortened or irregular interval. The outputs are single-clock enables in the reference domain and not derived clocks.

Top module: `refdiv_dualpost`

## Requirements
- R1: A synchronous reset clears both enables and the error flag. It loads ratio 10 (parameter default) and select code 00 for both channels.
- R2: Select code 00/01/10/11 sets a channel's postscale to 1/2/4/8. After reset is released, a channel's first pulse comes N·P clocks later, where N is the ratio and P the postscale. Later pulses follow every N·P clocks.
- R3: Every enable pulse is high for exactly one clock.
- R4: The main and auxiliary channels take independent select codes. Whenever the channel with the smaller postscale is due in the same clock as the other, both channels pulse in that clock.
- R5: Any ratio from 4 to 4095 divides correctly, including 4095 with postscale 8 (32760 clocks between pulses).
- R6: A written ratio below 4 is replaced by 4, and the error flag goes high on the clock after the write. The flag stays high until reset.
- R7: A write takes effect only at the end of the current eight-divider-period cascade cycle. A later write made before that point replaces an earlier pending one. Every interval between pulses equals a full old or a full new channel period.
- R8: Changes on the configuration inputs without the write strobe have no effect on either channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | One-cycle write strobe for the configuration inputs |
| cfg_ratio | input | 12 | Requested division ratio |
| cfg_main_sel | input | 2 | Postscale select for the main channel |
| cfg_aux_sel | input | 2 | Postscale select for the auxiliary channel |
| main_en | output | 1 | Main channel comparison enable pulse |
| aux_en | output | 1 | Auxiliary channel comparison enable pulse |
| ratio_err | output | 1 | Sticky flag: a ratio below the floor was written |

## Verification
The hardest case to reach is a reconfiguration that is still pending while the cascade is partway through its cycle. A second write then lands before the boundary, and the old ratio must keep running until the eighth divider expiry. The stimulus makes two writes a few clocks apart in the middle of a cascade cycle, using different ratios and selects. The bench model then predicts the exact switch-over clock. The largest ratio with the deepest tap is reached by a long run of more than two full 32760-clock periods, so that the deferred update and the wide counter are both covered.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
   localparam int NUM_CH  = 2;
   localparam int CH_MAIN = 0;
   localparam int CH_AUX  = 1;
endpackage

// File: rtl/refdiv_cfg.sv
module refdiv_cfg #(
   parameter int RATIO_W   = 12,
   parameter int SEL_W     = 2,
   parameter int NUM_CH    = 2,
   parameter int MIN_RATIO = 4,
   parameter int DEF_RATIO = 10
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      wr,
   input  logic [RATIO_W-1:0]        wr_ratio,
   input  logic [NUM_CH*SEL_W-1:0]   wr_sel,
   input  logic                      apply,
   output logic [RATIO_W-1:0]        ratio_next,
   output logic [NUM_CH*SEL_W-1:0]   act_sel,
   output logic                      err
);
   localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(MIN_RATIO);
   localparam logic [RATIO_W-1:0] DEFV  = RATIO_W'(DEF_RATIO);

   logic [RATIO_W-1:0]      pend_ratio, act_ratio, clamped;
   logic [NUM_CH*SEL_W-1:0] pend_sel;
   logic                    too_low;

   assign too_low = wr_ratio < FLOOR;
   assign clamped = too_low ? FLOOR : wr_ratio;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_ratio <= DEFV;
         act_ratio  <= DEFV;
         pend_sel   <= '0;
         act_sel    <= '0;
         err        <= 1'b0;
      end else begin
         if (apply) begin
            act_ratio <= pend_ratio;
            act_sel   <= pend_sel;
         end
         if (wr) begin
            pend_ratio <= clamped;
            pend_sel   <= wr_sel;
            if (too_low) err <= 1'b1;
         end
      end
   end

   assign ratio_next = apply ? pend_ratio : act_ratio;
endmodule

// File: rtl/refdiv_count.sv
module refdiv_count #(
   parameter int RATIO_W   = 12,
   parameter int STAGES    = 3,
   parameter int DEF_RATIO = 10
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [RATIO_W-1:0] ratio_next,
   output logic [STAGES:0]    carry
);
   logic [RATIO_W-1:0] div_cnt;
   logic [STAGES-1:0]  stage_q;

   assign carry[0] = (div_cnt == '0);

   always_ff @(posedge clk) begin
      if (rst)           div_cnt <= RATIO_W'(DEF_RATIO - 1);
      else if (carry[0]) div_cnt <= ratio_next - RATIO_W'(1);
      else               div_cnt <= div_cnt - RATIO_W'(1);
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic st_q;
      always_ff @(posedge clk) begin
         if (rst)           st_q <= 1'b0;
         else if (carry[i]) st_q <= ~st_q;
      end
      assign stage_q[i]  = st_q;
      assign carry[i+1]  = carry[i] & st_q;
   end
endmodule

// File: rtl/refdiv_tap.sv
module refdiv_tap #(
   parameter int SEL_W  = 2,
   parameter int STAGES = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] sel,
   input  logic [STAGES:0]  carry,
   output logic             en
);
   always_ff @(posedge clk) begin
      if (rst) en <= 1'b0;
      else     en <= carry[sel];
   end
endmodule

// File: rtl/refdiv_dualpost.sv
module refdiv_dualpost
   import refdiv_pkg::*;
#(
   parameter int RATIO_W   = 12,
   parameter int SEL_W     = 2,
   parameter int MIN_RATIO = 4,
   parameter int DEF_RATIO = 10
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cfg_wr,
   input  logic [RATIO_W-1:0] cfg_ratio,
   input  logic [SEL_W-1:0]   cfg_main_sel,
   input  logic [SEL_W-1:0]   cfg_aux_sel,
   output logic               main_en,
   output logic               aux_en,
   output logic               ratio_err
);
   localparam int STAGES = (1 << SEL_W) - 1;

   if (MIN_RATIO < 2) begin : g_bad_floor
      $error("refdiv_dualpost: MIN_RATIO must be at least 2");
   end
   if (DEF_RATIO < MIN_RATIO || DEF_RATIO >= (1 << RATIO_W)) begin : g_bad_def
      $error("refdiv_dualpost: DEF_RATIO outside legal range");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("refdiv_dualpost: SEL_W must be 1 to 4");
   end

   logic [NUM_CH*SEL_W-1:0] wr_sel, act_sel;
   logic [RATIO_W-1:0]      ratio_next;
   logic [STAGES:0]         carry;
   logic [NUM_CH-1:0]       ch_en;

   assign wr_sel = {cfg_aux_sel, cfg_main_sel};

   refdiv_cfg #(
      .RATIO_W(RATIO_W), .SEL_W(SEL_W), .NUM_CH(NUM_CH),
      .MIN_RATIO(MIN_RATIO), .DEF_RATIO(DEF_RATIO)
   ) cfg_i (
      .clk(clk), .rst(rst), .wr(cfg_wr), .wr_ratio(cfg_ratio),
      .wr_sel(wr_sel), .apply(carry[STAGES]),
      .ratio_next(ratio_next), .act_sel(act_sel), .err(ratio_err)
   );

   refdiv_count #(
      .RATIO_W(RATIO_W), .STAGES(STAGES), .DEF_RATIO(DEF_RATIO)
   ) count_i (
      .clk(clk), .rst(rst), .ratio_next(ratio_next), .carry(carry)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      refdiv_tap #(.SEL_W(SEL_W), .STAGES(STAGES)) tap_i (
         .clk(clk), .rst(rst),
         .sel(act_sel[ch*SEL_W +: SEL_W]),
         .carry(carry), .en(ch_en[ch])
      );
   end

   assign main_en = ch_en[CH_MAIN];
   assign aux_en  = ch_en[CH_AUX];
endmodule

// File: rtl/refdiv_dualpost_chk.sv
module refdiv_dualpost_chk #(
   parameter int RATIO_W   = 12,
   parameter int SEL_W     = 2,
   parameter int MIN_RATIO = 4
) (
   input logic               clk,
   input logic               rst,
   input logic               cfg_wr,
   input logic [RATIO_W-1:0] cfg_ratio,
   input logic               main_en,
   input logic               aux_en,
   input logic               ratio_err,
   input logic [2*SEL_W-1:0] act_sel
);
   logic [SEL_W-1:0] m_sel, a_sel;
   assign m_sel = act_sel[SEL_W-1:0];
   assign a_sel = act_sel[2*SEL_W-1:SEL_W];

   p_main_single_r3: assert property (@(posedge clk) disable iff (rst)
      main_en |=> !main_en);
   p_aux_single_r3: assert property (@(posedge clk) disable iff (rst)
      aux_en |=> !aux_en);
   p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      ratio_err |=> ratio_err);
   p_clamp_flag_r6: assert property (@(posedge clk) disable iff (rst)
      (cfg_wr && cfg_ratio < RATIO_W'(MIN_RATIO)) |=> ratio_err);
   p_aux_nested_r4: assert property (@(posedge clk) disable iff (rst)
      (aux_en && m_sel <= a_sel) |-> main_en);
   p_main_nested_r4: assert property (@(posedge clk) disable iff (rst)
      (main_en && a_sel <= m_sel) |-> aux_en);
endmodule

bind refdiv_dualpost refdiv_dualpost_chk #(
   .RATIO_W(RATIO_W), .SEL_W(SEL_W), .MIN_RATIO(MIN_RATIO)
) chk_i (
   .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_ratio(cfg_ratio),
   .main_en(main_en), .aux_en(aux_en), .ratio_err(ratio_err),
   .act_sel(act_sel)
);

// File: tb/refdiv_dualpost_tb_top.sv
module refdiv_dualpost_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEF_RATIO  = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_wr = 1'b0;
   logic [11:0] cfg_ratio = '0;
   logic [1:0]  cfg_main_sel = '0;
   logic [1:0]  cfg_aux_sel = '0;
   logic        main_en, aux_en, ratio_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   refdiv_dualpost #(.RATIO_W(12), .SEL_W(2), .MIN_RATIO(4), .DEF_RATIO(DEF_RATIO)) dut_i (
      .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_ratio(cfg_ratio),
      .cfg_main_sel(cfg_main_sel), .cfg_aux_sel(cfg_aux_sel),
      .main_en(main_en), .aux_en(aux_en), .ratio_err(ratio_err)
   );

   // behavioural model: clocks since the last eight-period boundary
   int t = 0, cur_r = DEF_RATIO, cur_m = 0, cur_a = 0;
   int pnd_r = DEF_RATIO, pnd_m = 0, pnd_a = 0;
   bit exp_m = 0, exp_a = 0, exp_err = 0;

   always @(posedge clk) begin
      if (rst) begin
         t = 0; cur_r = DEF_RATIO; cur_m = 0; cur_a = 0;
         pnd_r = DEF_RATIO; pnd_m = 0; pnd_a = 0;
         exp_m = 0; exp_a = 0; exp_err = 0;
      end else begin
         int k;
         t++;
         exp_m = 0; exp_a = 0;
         if (t % cur_r == 0) begin
            k = t / cur_r;
            exp_m = (k % (1 << cur_m)) == 0;
            exp_a = (k % (1 << cur_a)) == 0;
            if (k == 8) begin
               cur_r = pnd_r; cur_m = pnd_m; cur_a = pnd_a; t = 0;
            end
         end
         if (cfg_wr) begin
            pnd_r = (int'(cfg_ratio) < 4) ? 4 : int'(cfg_ratio);
            if (int'(cfg_ratio) < 4) exp_err = 1;
            pnd_m = int'(cfg_main_sel);
            pnd_a = int'(cfg_aux_sel);
         end
      end
   end

   int    n_chk = 0, n_err = 0;
   string tag = "R1";
   bit    done = 0;
   logic  prev_m = 1'b0, prev_a = 1'b0;

   task automatic check(input string rq, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   always @(negedge clk) begin
      if (!done) begin
         check(tag, main_en, exp_m);
         check("R4", aux_en, exp_a);
         check("R6", ratio_err, exp_err);
         check("R3", prev_m & main_en | prev_a & aux_en, 1'b0);
         prev_m = main_en;
         prev_a = aux_en;
      end
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_cfg(input int r, input int m, input int a);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_ratio = 12'(r); cfg_main_sel = 2'(m); cfg_aux_sel = 2'(a);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   initial begin
      tag = "R1";
      run(4);
      rst = 1'b0;
      tag = "R2";                 // default ratio, both taps at 1
      run(200);
      write_cfg(5, 1, 3);
      run(400);
      tag = "R4";                 // different taps on the two channels
      write_cfg(4, 3, 0);
      run(300);
      write_cfg(9, 2, 1);
      run(400);
      tag = "R6";                 // ratio 2 clamps to 4 and flags
      write_cfg(2, 0, 2);
      run(200);
      tag = "R8";                 // inputs move without the strobe
      @(negedge clk);
      cfg_ratio = 12'd100; cfg_main_sel = 2'd3; cfg_aux_sel = 2'd3;
      run(300);
      tag = "R7";                 // two writes inside one cascade cycle
      write_cfg(6, 2, 2);
      run(5);
      write_cfg(7, 1, 0);
      run(300);
      tag = "R5";                 // largest ratio with deepest tap
      write_cfg(4095, 0, 3);
      run(70000);
      tag = "R1";                 // reset clears the sticky flag
      rst = 1'b1;
      run(3);
      rst = 1'b0;
      run(100);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         finish_run();
      end
   end
endmodule